// File: doc/BRIEF.md
# Load/Store Address and Data Formatter

This block sits between the decode stage and the memory port of a small core. For a single load or store it does three things: it forms the effective address, it forms the value that updates the base register, and it aligns and sizes the data. It receives the base register value, a register or pre-shifted offset, two 4-bit immediate nibbles and a 5-bit transfer control field. A 2-bit access-size code and a signed-width select give the access size. The raw load word and the raw store word pass through the block as well.

The control field picks the addressing form. With post-index the access uses the base as it is, and the base always moves. With plain pre-index the access uses the offset address and the base stays unchanged. With pre-index and writeback the offset address is both used and written back. The up bit chooses whether the offset is added or subtracted. Halfword and signed accesses can take an 8-bit immediate built from the two nibbles in place of the register offset. Byte enables, right-aligned and extended load data, and size-masked store data are all produced in the same combinational pass.

Top module: `lsagu_top`

## Requirements
- R1: When control bit 4 (pre) is 0, `addr_o` equals `base_i`, `wb_en_o` is 1 and `wb_val_o` is the base moved by the offset.
- R2: When control bit 4 is 1 and bit 1 (writeback) is 0, `addr_o` is the base moved by the offset and `wb_en_o` is 0.
- R3: When control bits 4 and 1 are both 1, `addr_o` and `wb_val_o` both equal the base moved by the offset and `wb_en_o` is 1.
- R4: Control bit 3 (up) set adds the offset to the base; clear subtracts it, modulo 2^32.
- R5: For size codes 2'b10 (unsigned half) and 2'b11 (signed), control bit 2 set selects the zero-extended immediate `{imm_hi_i, imm_lo_i}` as offset and clear selects `reg_off_i`; for size codes 2'b00 (word) and 2'b01 (unsigned byte) the offset is always `reg_off_i`.
- R6: `be_o` is 4'b1111 for a word. For a byte it is 1 shifted left by `addr_o[1:0]`. For a halfword it is 4'b0011 when `addr_o[1]` is 0 and 4'b1100 when it is 1. Size 2'b11 is a halfword when `sgn_half_i` is 1 and a byte otherwise.
- R7: `ld_data_o` equals `ld_raw_i` for words; unsigned byte and halfword loads take the addressed lane (shift right by 8·`addr_o[1:0]`, or by 16·`addr_o[1]`) and zero-extend it.
- R8: Signed loads take the addressed lane the same way and sign-extend it from bit 7 (byte) or bit 15 (halfword).
- R9: With control bit 0 (load) at 0, `st_data_o` is `st_raw_i` masked to bits 7:0 for bytes, to bits 15:0 for halfwords, and whole for words. With the load bit at 1 it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| base_i | input | 32 | Base register value |
| reg_off_i | input | 32 | Register (or prepared) offset |
| imm_hi_i | input | 4 | Upper nibble of split immediate |
| imm_lo_i | input | 4 | Lower nibble of split immediate |
| ctrl_i | input | 5 | {pre, up, imm/byte, writeback, load}, bit 4 down to bit 0 |
| size_i | input | 2 | 00 word, 01 unsigned byte, 10 unsigned half, 11 signed |
| sgn_half_i | input | 1 | For size 11: 1 halfword, 0 byte |
| ld_raw_i | input | 32 | Raw word returned by memory |
| st_raw_i | input | 32 | Register value to be stored |
| addr_o | output | 32 | Access address |
| wb_val_o | output | 32 | New base register value |
| wb_en_o | output | 1 | Base register update enable |
| be_o | output | 4 | Byte lane enables |
| ld_data_o | output | 32 | Aligned, extended load data |
| st_data_o | output | 32 | Size-masked store data |

## Verification
The address path and the lane path meet in one cycle. In pre-indexed forms the low bits of the computed sum choose the byte lane. A subtraction that borrows across bits 1:0 therefore changes which bytes are enabled and which byte is extracted. The bench drives every control code with bases and offsets whose low bits differ, including subtractions that wrap below zero. In that same cycle it checks the address, the byte enables and the extracted load byte against a reference that derives the lane only from its own computed address.

// File: rtl/lsagu_pkg.sv
package lsagu_pkg;

    // Access size code on size_i
    typedef enum logic [1:0] {
        ACC_WORD   = 2'b00,
        ACC_UBYTE  = 2'b01,
        ACC_UHALF  = 2'b10,
        ACC_SIGNED = 2'b11
    } acc_e;

    // Transfer control field, bit 4 down to bit 0
    typedef struct packed {
        logic pre;    // 1: offset applied before access
        logic up;     // 1: add offset, 0: subtract
        logic sel;    // half/signed: 1 selects split immediate
        logic wbk;    // pre-index writeback
        logic load;   // 1: load, 0: store
    } xfer_ctl_t;

    // Resolved access width
    typedef enum logic [1:0] {
        WID_BYTE = 2'b00,
        WID_HALF = 2'b01,
        WID_WORD = 2'b10
    } wid_e;

    function automatic wid_e width_of(acc_e acc, logic sgn_half);
        case (acc)
            ACC_WORD:   return WID_WORD;
            ACC_UBYTE:  return WID_BYTE;
            ACC_UHALF:  return WID_HALF;
            default:    return sgn_half ? WID_HALF : WID_BYTE;
        endcase
    endfunction

    function automatic logic uses_split_imm(acc_e acc);
        return (acc == ACC_UHALF) || (acc == ACC_SIGNED);
    endfunction

endpackage

// File: rtl/lsagu_addr.sv
module lsagu_addr
    import lsagu_pkg::*;
#(
    parameter int AW = 32,
    parameter int NW = 4
) (
    input  logic [AW-1:0]   base_i,
    input  logic [AW-1:0]   reg_off_i,
    input  logic [NW-1:0]   imm_hi_i,
    input  logic [NW-1:0]   imm_lo_i,
    input  xfer_ctl_t       ctl_i,
    input  acc_e            acc_i,
    output logic [AW-1:0]   addr_o,
    output logic [AW-1:0]   wb_val_o,
    output logic            wb_en_o
);
    localparam int IW = 2 * NW;

    logic [AW-1:0] off;
    logic [AW-1:0] disp;
    logic [AW-1:0] sum;
    logic          split;

    always_comb begin
        split = uses_split_imm(acc_i) && ctl_i.sel;
        off   = split ? {{(AW-IW){1'b0}}, imm_hi_i, imm_lo_i} : reg_off_i;
        disp  = ctl_i.up ? off : (~off + {{(AW-1){1'b0}}, 1'b1});
        sum   = base_i + disp;
    end

    assign addr_o   = ctl_i.pre ? sum : base_i;
    assign wb_val_o = sum;
    assign wb_en_o  = ~ctl_i.pre | ctl_i.wbk;

    always_comb begin
        // R1
        post_index_chk: assert (ctl_i.pre || (wb_en_o && addr_o == base_i))
            else $error("post-index address or writeback enable wrong");
        // R2
        pre_no_wb_chk: assert (!(ctl_i.pre && !ctl_i.wbk) || !wb_en_o)
            else $error("pre-index without writeback enabled writeback");
        // R3
        pre_wb_chk: assert (!(ctl_i.pre && ctl_i.wbk) || (wb_en_o && addr_o == wb_val_o))
            else $error("pre-index writeback mismatch");
        // R4
        up_down_chk: assert (split ||
                             (ctl_i.up  && (wb_val_o - base_i) == reg_off_i) ||
                             (!ctl_i.up && (base_i - wb_val_o) == reg_off_i))
            else $error("offset direction wrong");
    end

endmodule

// File: rtl/lsagu_lane.sv
module lsagu_lane
    import lsagu_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [$clog2(DW/8)-1:0] lane_i,
    input  acc_e                    acc_i,
    input  logic                    sgn_half_i,
    input  logic                    load_i,
    input  logic [DW-1:0]           ld_raw_i,
    input  logic [DW-1:0]           st_raw_i,
    output logic [DW/8-1:0]         be_o,
    output logic [DW-1:0]           ld_data_o,
    output logic [DW-1:0]           st_data_o
);
    localparam int NB = DW / 8;
    localparam int LW = $clog2(NB);

    wid_e           wid;
    logic           sext;
    logic [LW-1:0]  lane_eff;
    logic [DW-1:0]  shifted;

    always_comb begin
        wid  = width_of(acc_i, sgn_half_i);
        sext = (acc_i == ACC_SIGNED);
        case (wid)
            WID_BYTE: lane_eff = lane_i;
            WID_HALF: lane_eff = {lane_i[LW-1:1], 1'b0};
            default:  lane_eff = '0;
        endcase
        shifted = ld_raw_i >> {lane_eff, 3'b000};
    end

    for (genvar g = 0; g < NB; g++) begin : g_be
        always_comb begin
            case (wid)
                WID_BYTE: be_o[g] = (lane_i == LW'(g));
                WID_HALF: be_o[g] = (lane_i[LW-1:1] == (LW-1)'(g / 2));
                default:  be_o[g] = 1'b1;
            endcase
        end
    end

    always_comb begin
        case (wid)
            WID_BYTE: ld_data_o = {{(DW-8){sext & shifted[7]}}, shifted[7:0]};
            WID_HALF: ld_data_o = {{(DW-16){sext & shifted[15]}}, shifted[15:0]};
            default:  ld_data_o = ld_raw_i;
        endcase
        if (load_i) begin
            st_data_o = '0;
        end else begin
            case (wid)
                WID_BYTE: st_data_o = {{(DW-8){1'b0}}, st_raw_i[7:0]};
                WID_HALF: st_data_o = {{(DW-16){1'b0}}, st_raw_i[15:0]};
                default:  st_data_o = st_raw_i;
            endcase
        end
    end

    always_comb begin
        // R6
        lane_count_chk: assert ((wid == WID_BYTE && $countones(be_o) == 1) ||
                                (wid == WID_HALF && $countones(be_o) == 2) ||
                                (wid == WID_WORD && $countones(be_o) == NB))
            else $error("byte enable count wrong");
        // R8
        sign_fill_chk: assert (!(sext && wid == WID_BYTE) ||
                               ld_data_o[DW-1:8] == {(DW-8){ld_data_o[7]}})
            else $error("signed byte fill wrong");
        // R7
        zero_fill_chk: assert (!(acc_i == ACC_UHALF) || ld_data_o[DW-1:16] == '0)
            else $error("unsigned half fill wrong");
        // R9
        store_mask_chk: assert (wid == WID_WORD || st_data_o[DW-1:16] == '0)
            else $error("store data not masked");
    end

endmodule

// File: rtl/lsagu_top.sv
module lsagu_top
    import lsagu_pkg::*;
#(
    parameter int DW = 32,
    parameter int NW = 4
) (
    input  logic [DW-1:0]   base_i,
    input  logic [DW-1:0]   reg_off_i,
    input  logic [NW-1:0]   imm_hi_i,
    input  logic [NW-1:0]   imm_lo_i,
    input  logic [4:0]      ctrl_i,
    input  logic [1:0]      size_i,
    input  logic            sgn_half_i,
    input  logic [DW-1:0]   ld_raw_i,
    input  logic [DW-1:0]   st_raw_i,
    output logic [DW-1:0]   addr_o,
    output logic [DW-1:0]   wb_val_o,
    output logic            wb_en_o,
    output logic [DW/8-1:0] be_o,
    output logic [DW-1:0]   ld_data_o,
    output logic [DW-1:0]   st_data_o
);
    localparam int LW = $clog2(DW / 8);

    xfer_ctl_t ctl;
    acc_e      acc;

    assign ctl = xfer_ctl_t'(ctrl_i);
    assign acc = acc_e'(size_i);

    lsagu_addr #(.AW(DW), .NW(NW)) u_addr (
        .base_i    (base_i),
        .reg_off_i (reg_off_i),
        .imm_hi_i  (imm_hi_i),
        .imm_lo_i  (imm_lo_i),
        .ctl_i     (ctl),
        .acc_i     (acc),
        .addr_o    (addr_o),
        .wb_val_o  (wb_val_o),
        .wb_en_o   (wb_en_o)
    );

    lsagu_lane #(.DW(DW)) u_lane (
        .lane_i     (addr_o[LW-1:0]),
        .acc_i      (acc),
        .sgn_half_i (sgn_half_i),
        .load_i     (ctl.load),
        .ld_raw_i   (ld_raw_i),
        .st_raw_i   (st_raw_i),
        .be_o       (be_o),
        .ld_data_o  (ld_data_o),
        .st_data_o  (st_data_o)
    );

endmodule

// File: tb/lsagu_top_tb_top.sv
module lsagu_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] base, roff, ldr, str_d;
    logic [3:0]  ihi, ilo;
    logic [4:0]  ctrl;
    logic [1:0]  size;
    logic        sgh;
    logic [31:0] addr, wbv, ldd, std;
    logic        wbe;
    logic [3:0]  be;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    lsagu_top dut_i (
        .base_i(base), .reg_off_i(roff), .imm_hi_i(ihi), .imm_lo_i(ilo),
        .ctrl_i(ctrl), .size_i(size), .sgn_half_i(sgh),
        .ld_raw_i(ldr), .st_raw_i(str_d),
        .addr_o(addr), .wb_val_o(wbv), .wb_en_o(wbe), .be_o(be),
        .ld_data_o(ldd), .st_data_o(std)
    );

    task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // Behavioural reference, compared at the falling edge of every cycle
    task automatic check_now();
        logic [31:0] off, sum, e_addr, e_ld, e_st;
        logic [3:0]  e_be;
        int          lane, nbytes;
        bit          hs, sx;
        hs = (size == 2'b10) || (size == 2'b11);
        off = (hs && ctrl[2]) ? {24'h0, ihi, ilo} : roff;
        sum = ctrl[3] ? base + off : base - off;
        e_addr = ctrl[4] ? sum : base;
        lane = int'(e_addr[1:0]);
        sx = (size == 2'b11);
        if (size == 2'b00) nbytes = 4;
        else if (size == 2'b10 || (sx && sgh)) nbytes = 2;
        else nbytes = 1;
        if (nbytes == 4) begin
            e_be = 4'hf; e_ld = ldr; e_st = str_d;
        end else if (nbytes == 2) begin
            e_be = e_addr[1] ? 4'hc : 4'h3;
            e_ld = (ldr >> (e_addr[1] ? 16 : 0)) & 32'hffff;
            if (sx && e_ld[15]) e_ld = e_ld | 32'hffff0000;
            e_st = str_d & 32'hffff;
        end else begin
            e_be = 4'b0001 << lane;
            e_ld = (ldr >> (8 * lane)) & 32'hff;
            if (sx && e_ld[7]) e_ld = e_ld | 32'hffffff00;
            e_st = str_d & 32'hff;
        end
        if (ctrl[0]) e_st = 32'h0;
        cmp(ctrl[4] ? (ctrl[1] ? "R3 addr" : "R2 addr") : "R1 addr", addr, e_addr);
        cmp(ctrl[4] ? (ctrl[1] ? "R3 wb_en" : "R2 wb_en") : "R1 wb_en",
            {31'h0, wbe}, {31'h0, (!ctrl[4] || ctrl[1])});
        cmp(hs ? "R5 wb_val" : "R4 wb_val", wbv, sum);
        cmp("R6 be", {28'h0, be}, {28'h0, e_be});
        cmp(sx ? "R8 ld_data" : "R7 ld_data", ldd, e_ld);
        cmp("R9 st_data", std, e_st);
    endtask

    task automatic apply(logic [31:0] b, logic [31:0] r, logic [3:0] h, logic [3:0] l,
                         logic [4:0] c, logic [1:0] s, logic g,
                         logic [31:0] ld, logic [31:0] sd);
        @(posedge clk);
        base = b; roff = r; ihi = h; ilo = l; ctrl = c; size = s; sgh = g;
        ldr = ld; str_d = sd;
        @(negedge clk);
        check_now();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        base = '0; roff = '0; ihi = '0; ilo = '0; ctrl = '0; size = '0; sgh = 1'b0;
        ldr = '0; str_d = '0;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        // Idle state: zero inputs, post-index word store
        @(negedge clk);
        check_now();
        // R1 post-index, subtract wrapping below zero
        apply(32'h0000_0001, 32'h0000_0003, 4'h0, 4'h0, 5'b00000, 2'b01, 1'b0,
              32'hA1B2C3D4, 32'h1234_5678);
        // R2 pre-index, lane change through borrow, R8 signed byte
        apply(32'h0000_1000, 32'h0000_0001, 4'h0, 4'h0, 5'b10001, 2'b11, 1'b0,
              32'h80FF_7F01, 32'h0);
        // R3 pre-index writeback with split immediate max, R5
        apply(32'h0000_2002, 32'h0000_0000, 4'hF, 4'hF, 5'b11111, 2'b10, 1'b0,
              32'h8001_7FFE, 32'h0);
        // R5 bit2 clear on halfword uses register offset
        apply(32'h0000_2000, 32'h0000_0006, 4'hF, 4'hF, 5'b11010, 2'b11, 1'b1,
              32'h8001_7FFE, 32'hDEAD_BEEF);
        // R5 word ignores split immediate even with bit2 set
        apply(32'h0000_0100, 32'h0000_0010, 4'h7, 4'h7, 5'b11100, 2'b00, 1'b0,
              32'h0, 32'hCAFE_F00D);
        // Sweep every control code, size and lane
        for (int c = 0; c < 32; c++)
            for (int s = 0; s < 4; s++)
                for (int k = 0; k < 8; k++)
                    apply($urandom, (k < 4) ? 32'(k) : $urandom % 64, 4'($urandom), 4'($urandom),
                          5'(c), 2'(s), 1'(k), $urandom, $urandom);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule